// File: doc/BRIEF.md
# Handshaked Two-Operand Adder

This block adds two 4-bit unsigned operands that reach it over two separate valid/ready channels and delivers the 5-bit sum over a third valid/ready channel. The two operand producers are unrelated. Either one may go quiet for any number of cycles. Meanwhile the consumer of the sum may stall the result channel at any time. The block pairs the N-th operand A with the N-th operand B and returns their sums in order.

A join stage takes both operands in the same cycle. It takes them only when both are valid and the output buffer can accept an entry. A starved operand therefore waits at its producer and is never taken alone. The sum goes through an output buffer whose structure is fixed at elaboration by the `KIND` parameter. The choices are:

- `BUF_PIPE`: a single register with full throughput. Its ready depends combinationally on `res_ready`.
- `BUF_HALF`: a single register with no combinational ready path. It delivers at most one result every two cycles.
- `BUF_STALL`: a single register that advances only when `res_ready` is high.
- `BUF_FIFO2`: a two-entry queue with full throughput and no combinational ready path.

The default is `BUF_PIPE`.

Back-pressure rules on every channel:
- A transfer happens at a rising edge where valid and ready are both high.
- A sender holds valid and data unchanged until that edge.
- Ready may rise or fall at any time.

Top module: `hs_adder`

## Requirements
- R1: The first clock edge with `rst` high clears the buffer. From then until operands are offered, `res_valid` is low and both operand readys are low.
- R2: Each result equals `opa_data + opb_data` as an unsigned 5-bit value, with bit 4 holding the carry. For example, 15 + 15 gives 30 and 0 + 0 gives 0.
- R3: `opa_ready` and `opb_ready` are always equal. They are high only when both `opa_valid` and `opb_valid` are high.
- R4: While only one operand is valid, both readys stay low and no result is produced. The waiting operand is later added to the operand that arrives on the other channel.
- R5: Results leave in the order the operand pairs were taken. Each pair produces exactly one result, whatever pattern `res_ready` follows.
- R6: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_data` stays unchanged on the next cycle.
- R7: With the default buffer, a continuous supply of operands, and `res_ready` held high, one result is transferred every clock cycle.
- R8: With the default buffer, a pair taken at a clock edge appears on `res_valid`/`res_data` directly after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opa_valid | input | 1 | Operand A offered |
| opa_ready | output | 1 | Operand A taken at this edge |
| opa_data | input | 4 | Operand A value |
| opb_valid | input | 1 | Operand B offered |
| opb_ready | output | 1 | Operand B taken at this edge |
| opb_data | input | 4 | Operand B value |
| res_valid | output | 1 | Sum offered |
| res_ready | input | 1 | Consumer accepts the sum |
| res_data | output | 5 | Sum with carry in the top bit |

## Verification
The assertions rely on two producer rules. First, each operand producer keeps its valid high and its data steady until the operand is taken. Second, the result consumer never sees a sum that was not offered; this follows from the handshake itself. The bench drivers raise valid on a falling edge and release it only on the falling edge after a cycle in which ready was seen high, so the producer rule always holds. The random gaps on each operand channel are drawn independently, as are the random settings of `res_ready`, so starvation on either side and output stalls overlap freely within those rules.

// File: rtl/hs_adder_pkg.sv
package hs_adder_pkg;

  typedef enum logic [1:0] {
    BUF_PIPE  = 2'd0,
    BUF_HALF  = 2'd1,
    BUF_STALL = 2'd2,
    BUF_FIFO2 = 2'd3
  } buf_kind_e;

  // Number of results a buffer kind can hold at once
  function automatic int unsigned buf_capacity(buf_kind_e kind);
    return (kind == BUF_FIFO2) ? 2 : 1;
  endfunction

endpackage

// File: rtl/hs_adder_join.sv
module hs_adder_join #(
  parameter int W = 4
) (
  input  logic         a_valid,
  input  logic [W-1:0] a_data,
  output logic         a_ready,
  input  logic         b_valid,
  input  logic [W-1:0] b_data,
  output logic         b_ready,
  output logic         up_valid,
  output logic [W:0]   up_sum,
  input  logic         up_ready
);

  logic both_here;

  // A pair exists only when both channels offer an operand
  assign both_here = a_valid & b_valid;
  assign up_valid  = both_here;

  // Both operands are consumed together, never one alone
  assign a_ready = both_here & up_ready;
  assign b_ready = both_here & up_ready;

  // Zero-extended add keeps the carry in the top bit
  assign up_sum = {1'b0, a_data} + {1'b0, b_data};

endmodule

// File: rtl/hs_adder_outbuf.sv
module hs_adder_outbuf
  import hs_adder_pkg::*;
#(
  parameter int        DW   = 5,
  parameter buf_kind_e KIND = BUF_PIPE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_valid,
  input  logic [DW-1:0] up_data,
  output logic          up_ready,
  output logic          down_valid,
  output logic [DW-1:0] down_data,
  input  logic          down_ready
);

  generate
    if (KIND == BUF_PIPE) begin : g_pipe
      logic          full_q;
      logic [DW-1:0] data_q;

      // Refill in the same cycle the held item leaves
      assign up_ready   = ~full_q | down_ready;
      assign down_valid = full_q;
      assign down_data  = data_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          full_q <= 1'b0;
        end else if (up_ready) begin
          full_q <= up_valid;
        end
      end

      always_ff @(posedge clk) begin
        if (up_ready && up_valid) begin
          data_q <= up_data;
        end
      end

    end else if (KIND == BUF_HALF) begin : g_half
      logic          full_q;
      logic [DW-1:0] data_q;

      // Ready comes straight from a flop: accept only when empty
      assign up_ready   = ~full_q;
      assign down_valid = full_q;
      assign down_data  = data_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          full_q <= 1'b0;
        end else if (full_q) begin
          if (down_ready) begin
            full_q <= 1'b0;
          end
        end else if (up_valid) begin
          full_q <= 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (!full_q && up_valid) begin
          data_q <= up_data;
        end
      end

    end else if (KIND == BUF_STALL) begin : g_stall
      logic          full_q;
      logic [DW-1:0] data_q;

      // Whole register moves only when the consumer is ready
      assign up_ready   = down_ready;
      assign down_valid = full_q;
      assign down_data  = data_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          full_q <= 1'b0;
        end else if (down_ready) begin
          full_q <= up_valid;
        end
      end

      always_ff @(posedge clk) begin
        if (down_ready && up_valid) begin
          data_q <= up_data;
        end
      end

    end else begin : g_fifo2
      localparam int DEPTH = 2;
      localparam int PW    = $clog2(DEPTH);
      localparam int CW    = $clog2(DEPTH + 1);

      logic [DW-1:0] slot_q [DEPTH];
      logic [PW-1:0] wr_q;
      logic [PW-1:0] rd_q;
      logic [CW-1:0] cnt_q;
      logic          push;
      logic          pop;

      assign up_ready   = (cnt_q != CW'(DEPTH));
      assign down_valid = (cnt_q != '0);
      assign down_data  = slot_q[rd_q];
      assign push       = up_valid & up_ready;
      assign pop        = down_valid & down_ready;

      always_ff @(posedge clk) begin
        if (rst) begin
          wr_q  <= '0;
          rd_q  <= '0;
          cnt_q <= '0;
        end else begin
          if (push) begin
            wr_q <= wr_q + 1'b1;
          end
          if (pop) begin
            rd_q <= rd_q + 1'b1;
          end
          if (push && !pop) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (pop && !push) begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end

      always_ff @(posedge clk) begin
        if (push) begin
          slot_q[wr_q] <= up_data;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/hs_adder.sv
module hs_adder
  import hs_adder_pkg::*;
#(
  parameter int        W    = 4,
  parameter buf_kind_e KIND = BUF_PIPE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         opa_valid,
  output logic         opa_ready,
  input  logic [W-1:0] opa_data,
  input  logic         opb_valid,
  output logic         opb_ready,
  input  logic [W-1:0] opb_data,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W:0]   res_data
);

  localparam int DW  = W + 1;
  localparam int CAP = buf_capacity(KIND);

  logic          pair_valid;
  logic          pair_ready;
  logic [DW-1:0] pair_sum;

  hs_adder_join #(
    .W(W)
  ) u_join (
    .a_valid (opa_valid),
    .a_data  (opa_data),
    .a_ready (opa_ready),
    .b_valid (opb_valid),
    .b_data  (opb_data),
    .b_ready (opb_ready),
    .up_valid(pair_valid),
    .up_sum  (pair_sum),
    .up_ready(pair_ready)
  );

  hs_adder_outbuf #(
    .DW  (DW),
    .KIND(KIND)
  ) u_obuf (
    .clk       (clk),
    .rst       (rst),
    .up_valid  (pair_valid),
    .up_data   (pair_sum),
    .up_ready  (pair_ready),
    .down_valid(res_valid),
    .down_data (res_data),
    .down_ready(res_ready)
  );

endmodule

// File: rtl/hs_adder_chk.sv
module hs_adder_chk #(
  parameter int W   = 4,
  parameter int CAP = 1
) (
  input logic         clk,
  input logic         rst,
  input logic         opa_valid,
  input logic         opa_ready,
  input logic [W-1:0] opa_data,
  input logic         opb_valid,
  input logic         opb_ready,
  input logic [W-1:0] opb_data,
  input logic         res_valid,
  input logic         res_ready,
  input logic [W:0]   res_data
);

  logic rst_seen = 1'b0;
  int   held;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
  end

  // Results taken in but not yet delivered
  always_ff @(posedge clk) begin
    if (rst) begin
      held <= 0;
    end else begin
      held <= held + int'(opa_valid && opa_ready) - int'(res_valid && res_ready);
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst_seen |-> !res_valid);

  // R3
  ready_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (opa_ready == opb_ready) && (!opa_ready || (opa_valid && opb_valid)));

  // R4
  starve_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (opa_valid != opb_valid) |-> (!opa_ready && !opb_ready));

  // R5
  no_overfill_chk: assert property (@(posedge clk) disable iff (rst)
    (held >= 0) && (held <= CAP));

  // R5
  no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (held != 0));

  // R6
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R4 producer rule the checks above rely on
  opa_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (opa_valid && !opa_ready) |=> (opa_valid && $stable(opa_data)));

  // R4 producer rule the checks above rely on
  opb_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (opb_valid && !opb_ready) |=> (opb_valid && $stable(opb_data)));

endmodule

bind hs_adder hs_adder_chk #(
  .W  (W),
  .CAP(CAP)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opa_valid(opa_valid),
  .opa_ready(opa_ready),
  .opa_data (opa_data),
  .opb_valid(opb_valid),
  .opb_ready(opb_ready),
  .opb_data (opb_data),
  .res_valid(res_valid),
  .res_ready(res_ready),
  .res_data (res_data)
);

// File: tb/hs_adder_tb.sv
module hs_adder_tb;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         opa_valid = 1'b0;
  logic         opa_ready;
  logic [W-1:0] opa_data = '0;
  logic         opb_valid = 1'b0;
  logic         opb_ready;
  logic [W-1:0] opb_data = '0;
  logic         res_valid;
  logic         res_ready = 1'b0;
  logic [W:0]   res_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rcvd   = 0;
  int sink_mode = 2;   // 0 random, 1 always ready, 2 never ready
  int first_cyc = -1;
  int last_cyc  = -1;
  bit done = 1'b0;

  logic [W-1:0] qa[$];
  logic [W-1:0] qb[$];

  always #10 clk = ~clk;   // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  hs_adder u_dut (
    .clk      (clk),
    .rst      (rst),
    .opa_valid(opa_valid),
    .opa_ready(opa_ready),
    .opa_data (opa_data),
    .opb_valid(opb_valid),
    .opb_ready(opb_ready),
    .opb_data (opb_data),
    .res_valid(res_valid),
    .res_ready(res_ready),
    .res_data (res_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [W-1:0] pick(input int i);
    if (i == 0) return '1;
    if (i == 1) return '0;
    return W'($urandom);
  endfunction

  task automatic drive_a(input int n, input int maxgap);
    for (int i = 0; i < n; i++) begin
      repeat (maxgap == 0 ? 0 : $urandom_range(maxgap, 0)) @(negedge clk);
      opa_valid = 1'b1;
      opa_data  = pick(i);
      qa.push_back(opa_data);
      forever begin
        #5;
        if (opa_ready) break;
        @(negedge clk);
      end
      @(negedge clk);
      opa_valid = 1'b0;
    end
  endtask

  task automatic drive_b(input int n, input int maxgap);
    for (int i = 0; i < n; i++) begin
      repeat (maxgap == 0 ? 0 : $urandom_range(maxgap, 0)) @(negedge clk);
      opb_valid = 1'b1;
      opb_data  = pick(i);
      qb.push_back(opb_data);
      forever begin
        #5;
        if (opb_ready) break;
        @(negedge clk);
      end
      @(negedge clk);
      opb_valid = 1'b0;
    end
  endtask

  // Sink: sets res_ready on each falling edge
  always @(negedge clk) begin
    case (sink_mode)
      0:       res_ready <= ($urandom_range(3, 0) != 0);
      1:       res_ready <= 1'b1;
      default: res_ready <= 1'b0;
    endcase
  end

  // Monitor: scoreboard compare and hold check on the result channel
  initial begin
    bit           hold_prev = 1'b0;
    logic [W:0]   data_prev = '0;
    logic [W:0]   exp_sum;
    forever begin
      @(negedge clk);
      #6;
      if (!rst) begin
        if (hold_prev) begin
          // R6
          check(res_valid === 1'b1 && res_data === data_prev, "R6", int'(res_data), int'(data_prev));
        end
        if (res_valid && res_ready) begin
          if (qa.size() == 0 || qb.size() == 0) begin
            // R5 result with no operand pair behind it
            check(1'b0, "R5", int'(res_data), -1);
          end else begin
            exp_sum = {1'b0, qa.pop_front()} + {1'b0, qb.pop_front()};
            // R2 and R5: value and order
            check(res_data === exp_sum, "R2/R5", int'(res_data), int'(exp_sum));
          end
          rcvd++;
          if (first_cyc < 0) first_cyc = cyc;
          last_cyc = cyc;
        end
        hold_prev = res_valid && !res_ready;
        data_prev = res_data;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_up();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #5;
    check(res_valid === 1'b0, "R1", int'(res_valid), 0);
    check(opa_ready === 1'b0 && opb_ready === 1'b0, "R1", int'(opa_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    #5;
    check(res_valid === 1'b0, "R1", int'(res_valid), 0);

    // R4: operand A alone, B starved
    opa_valid = 1'b1;
    opa_data  = 4'd9;
    qa.push_back(4'd9);
    for (int i = 0; i < 6; i++) begin
      #5;
      check(opa_ready === 1'b0 && opb_ready === 1'b0, "R4", int'(opa_ready), 0);
      check(res_valid === 1'b0, "R4", int'(res_valid), 0);
      @(negedge clk);
    end
    // R3: partner arrives, both readys rise together
    opb_valid = 1'b1;
    opb_data  = 4'd12;
    qb.push_back(4'd12);
    #5;
    check(opa_ready === 1'b1 && opb_ready === 1'b1, "R3", int'(opb_ready), 1);
    @(negedge clk);
    opa_valid = 1'b0;
    opb_valid = 1'b0;
    #6;
    // R8: pair taken at the edge is on the output right after it
    check(res_valid === 1'b1 && res_data === 5'd21, "R8", int'(res_data), 21);
    // R6: output stalled for a few cycles (monitor checks hold)
    repeat (4) @(negedge clk);
    sink_mode = 1;
    wait (rcvd == 1);

    // R4 mirrored: B waits for A
    @(negedge clk);
    opb_valid = 1'b1;
    opb_data  = 4'd3;
    qb.push_back(4'd3);
    repeat (3) begin
      #5;
      check(opb_ready === 1'b0 && res_valid === 1'b0, "R4", int'(opb_ready), 0);
      @(negedge clk);
    end
    opa_valid = 1'b1;
    opa_data  = 4'd4;
    qa.push_back(4'd4);
    @(negedge clk);
    opa_valid = 1'b0;
    opb_valid = 1'b0;
    wait (rcvd == 2);

    // R5 and R2: random gaps on both operands, random back-pressure
    sink_mode = 0;
    fork
      drive_a(200, 3);
      drive_b(200, 4);
    join
    sink_mode = 1;
    wait (rcvd == 202);
    check(qa.size() == 0 && qb.size() == 0, "R5", qa.size() + qb.size(), 0);

    // R7: continuous supply, consumer always ready
    repeat (3) @(negedge clk);
    first_cyc = -1;
    fork
      drive_a(40, 0);
      drive_b(40, 0);
    join
    wait (rcvd == 242);
    check(last_cyc - first_cyc == 39, "R7", last_cyc - first_cyc, 39);

    repeat (3) @(negedge clk);
    check(res_valid === 1'b0, "R5", int'(res_valid), 0);
    finish_up();
  end

endmodule